// File: doc/BRIEF.md
# CCD Line Framer with Black-Level Clamp

This block sits behind the analog-to-digital converter of one color channel of a linear image sensor. It receives one digitized sample per pixel clock together with a line-start strobe and the pixel position that the timing generator assigns to that sample. A full sensor line is 2775 positions long. Positions 1 to 63 are leading dummy pixels, and a 49-pixel optically shielded span lies inside them. Positions 64 to 2763 carry the 2700 effective pixels, in order from the first to the last. Positions 2764 to 2775 are trailing dummy pixels.

For every line the block sums the samples at positions 2 to 12, which is 11 early dummy pixels. It turns that sum into a black level by multiplying with a fixed-point reciprocal. The black level is latched before the first effective pixel arrives. The block then subtracts it from every effective sample, clamping at zero, and emits only the effective pixels. Each output carries a valid flag, and the first and last pixels of the line are marked. If a new line-start strobe arrives before the current line has delivered all of its samples, the block stops emitting the unfinished line and raises a one-cycle error flag. The new line then starts at once.

Top module: `ccd_line_framer`

## Requirements
- R1: While reset is held and in the first cycle after it, `pixValid`, `pixFirst`, `pixLast`, `lineErr` and `pixOut` are all zero.
- R2: A sample belongs to a line if it arrives with `lineStart` high, or if it is one of the next LINE_LEN-1 samples after it. A belonging sample whose `pixIdx` lies in LEAD+1..LEAD+EFF produces exactly one output with `pixValid` high, one clock later. No other sample produces an output.
- R3: `pixFirst` is high together with the output of the sample at `pixIdx` = LEAD+1. `pixLast` is high together with the output of the sample at `pixIdx` = LEAD+EFF. Neither flag is ever high without `pixValid`.
- R4: The black level of a line is floor(S / N), where S is the sum of that line's samples at `pixIdx` BLK_FIRST..BLK_LAST and N = BLK_LAST-BLK_FIRST+1. The division uses a reciprocal constant that is exact for every reachable S.
- R5: `pixOut` is sample minus black level when the sample is at least the black level, and zero otherwise. Its width equals the input width.
- R6: Samples at every position outside BLK_FIRST..BLK_LAST have no effect on the black level. This includes the remaining leading dummy pixels, the optically shielded span and the trailing dummy pixels.
- R7: A `lineStart` that arrives while a line still expects samples produces `lineErr` high for exactly one cycle, one clock later. No further output of the unfinished line appears, and the strobe begins a new line.
- R8: Samples that belong to no line produce no output, whatever their `pixIdx` is. This covers samples before the first `lineStart` and samples after a line's LINE_LEN-th sample.
- R9: Every line is clamped with the black level taken from its own window. The level is latched at position BLK_LAST+1, before the first effective pixel, and it holds at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | High with the first sample of a line |
| pixIdx | input | IDX_W | Position of the current sample within the line, from 1 |
| sampleIn | input | DATA_W | Digitized sample |
| pixOut | output | DATA_W | Black-clamped effective pixel |
| pixValid | output | 1 | `pixOut` carries an effective pixel |
| pixFirst | output | 1 | First effective pixel of the line |
| pixLast | output | 1 | Last effective pixel of the line |
| lineErr | output | 1 | One-cycle pulse: the previous line was cut short |

## Verification
A truncating line-start strobe reports the error for the old line in the same cycle that it clears the black accumulator and opens the window for the new line. A flaw in either function would corrupt the other. The bench cuts lines short at two points: once in the middle of the effective pixels and once inside the black window. It follows each cut line with a complete line whose window samples differ. The cycle after the cut must show the error pulse and no stray output. The complete line that follows must be clamped with a black level computed only from its own window.

// File: rtl/cf_pkg.sv
package cf_pkg;

  // Strobes from the control to the datapath, valid in the cycle of the sample
  typedef struct packed {
    logic sumClr;      // first sample of a new line: restart the black sum
    logic sumAdd;      // sample lies in the black window
    logic blackLatch;  // window complete: capture the black level
    logic effValid;    // sample is an effective pixel
    logic effFirst;    // first effective pixel
    logic effLast;     // last effective pixel
    logic lineErr;     // previous line was cut short
  } frameStrobes_t;

endpackage

// File: rtl/cf_ctrl.sv
module cf_ctrl
  import cf_pkg::*;
#(
  parameter int LEAD      = 63,
  parameter int EFF       = 2700,
  parameter int TRAIL     = 12,
  parameter int BLK_FIRST = 2,
  parameter int BLK_LAST  = 12,
  parameter int IDX_W     = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStart,
  input  logic [IDX_W-1:0] pixIdx,
  output frameStrobes_t    str
);

  localparam int LINE_LEN = LEAD + EFF + TRAIL;
  localparam int CNT_W    = $clog2(LINE_LEN + 1);

  localparam logic [IDX_W-1:0] WIN_LO  = IDX_W'(BLK_FIRST);
  localparam logic [IDX_W-1:0] WIN_HI  = IDX_W'(BLK_LAST);
  localparam logic [IDX_W-1:0] LATCH_I = IDX_W'(BLK_LAST + 1);
  localparam logic [IDX_W-1:0] EFF_LO  = IDX_W'(LEAD + 1);
  localparam logic [IDX_W-1:0] EFF_HI  = IDX_W'(LEAD + EFF);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LINE_LEN);

  logic             inLine;   // further samples of the current line are expected
  logic [CNT_W-1:0] posCnt;   // samples of the current line seen so far
  logic             belongs;

  assign belongs = lineStart | inLine;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inLine <= 1'b0;
      posCnt <= '0;
    end else if (lineStart) begin
      inLine <= (LINE_LEN > 1);
      posCnt <= CNT_W'(1);
    end else if (inLine) begin
      posCnt <= posCnt + CNT_W'(1);
      if (posCnt + CNT_W'(1) == CNT_END) inLine <= 1'b0;
    end
  end

  always_comb begin
    str            = '0;
    str.sumClr     = lineStart;
    str.sumAdd     = belongs && (pixIdx >= WIN_LO) && (pixIdx <= WIN_HI);
    str.blackLatch = belongs && (pixIdx == LATCH_I);
    str.effValid   = belongs && (pixIdx >= EFF_LO) && (pixIdx <= EFF_HI);
    str.effFirst   = str.effValid && (pixIdx == EFF_LO);
    str.effLast    = str.effValid && (pixIdx == EFF_HI);
    str.lineErr    = lineStart && inLine;
  end

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    posCnt <= CNT_END);

  // R7
  start_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> (posCnt == CNT_W'(1)));

  // R2
  class_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.sumAdd, str.blackLatch, str.effValid}));

endmodule

// File: rtl/cf_datapath.sv
module cf_datapath
  import cf_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int NBLK   = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  frameStrobes_t     str,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [DATA_W-1:0] pixOut,
  output logic              pixValid,
  output logic              pixFirst,
  output logic              pixLast,
  output logic              lineErr
);

  localparam int SUM_W  = DATA_W + $clog2(NBLK + 1);
  localparam int SHIFT  = SUM_W + $clog2(NBLK) + 1;
  localparam int PROD_W = SUM_W + SHIFT + 1;
  localparam longint unsigned RECIP_L =
    ((64'd1 << SHIFT) + longint'(NBLK) - 64'd1) / longint'(NBLK);
  localparam logic [PROD_W-1:0] RECIP = PROD_W'(RECIP_L);

  logic [SUM_W-1:0]  sumAcc;
  logic [PROD_W-1:0] prod;
  logic [DATA_W-1:0] blackLevel;
  logic [DATA_W-1:0] clamped;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumAcc <= '0;
    end else if (str.sumClr) begin
      sumAcc <= str.sumAdd ? SUM_W'(sampleIn) : '0;
    end else if (str.sumAdd) begin
      sumAcc <= sumAcc + SUM_W'(sampleIn);
    end
  end

  assign prod = PROD_W'(sumAcc) * RECIP;

  always_ff @(posedge clk) begin
    if (!rstN)               blackLevel <= '0;
    else if (str.blackLatch) blackLevel <= DATA_W'(prod >> SHIFT);
  end

  assign clamped = (sampleIn >= blackLevel) ? (sampleIn - blackLevel) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOut   <= '0;
      pixValid <= 1'b0;
      pixFirst <= 1'b0;
      pixLast  <= 1'b0;
      lineErr  <= 1'b0;
    end else begin
      pixOut   <= str.effValid ? clamped : '0;
      pixValid <= str.effValid;
      pixFirst <= str.effFirst;
      pixLast  <= str.effLast;
      lineErr  <= str.lineErr;
    end
  end

  // R5
  no_gain_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> (pixOut <= $past(sampleIn)));

  // R3
  flag_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixFirst || pixLast) |-> pixValid);

  // R9
  black_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(str.blackLatch) |-> $stable(blackLevel));

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.lineErr |=> lineErr);

endmodule

// File: rtl/ccd_line_framer.sv
module ccd_line_framer
  import cf_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int LEAD_DUMMY  = 63,
  parameter int EFF_PIX     = 2700,
  parameter int TRAIL_DUMMY = 12,
  parameter int BLK_FIRST   = 2,
  parameter int BLK_LAST    = 12,
  localparam int LINE_LEN   = LEAD_DUMMY + EFF_PIX + TRAIL_DUMMY,
  localparam int IDX_W      = $clog2(LINE_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStart,
  input  logic [IDX_W-1:0]  pixIdx,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [DATA_W-1:0] pixOut,
  output logic              pixValid,
  output logic              pixFirst,
  output logic              pixLast,
  output logic              lineErr
);

  localparam int NBLK = BLK_LAST - BLK_FIRST + 1;

  frameStrobes_t str;

  cf_ctrl #(
    .LEAD      (LEAD_DUMMY),
    .EFF       (EFF_PIX),
    .TRAIL     (TRAIL_DUMMY),
    .BLK_FIRST (BLK_FIRST),
    .BLK_LAST  (BLK_LAST),
    .IDX_W     (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lineStart (lineStart),
    .pixIdx    (pixIdx),
    .str       (str)
  );

  cf_datapath #(
    .DATA_W (DATA_W),
    .NBLK   (NBLK)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .str      (str),
    .sampleIn (sampleIn),
    .pixOut   (pixOut),
    .pixValid (pixValid),
    .pixFirst (pixFirst),
    .pixLast  (pixLast),
    .lineErr  (lineErr)
  );

  initial begin
    if (BLK_FIRST < 1 || BLK_LAST < BLK_FIRST || BLK_LAST + 1 > LEAD_DUMMY)
      $error("black window must end at least one position before the effective pixels");
  end

endmodule

// File: tb/ccd_line_framer_tb.sv
`timescale 1ns/1ps
module ccd_line_framer_tb;

  localparam int DW    = 6;
  localparam int LEAD  = 8;
  localparam int EFF   = 10;
  localparam int TRAIL = 3;
  localparam int BF    = 2;
  localparam int BL    = 5;
  localparam int LLEN  = LEAD + EFF + TRAIL;
  localparam int NB    = BL - BF + 1;
  localparam int IW    = $clog2(LLEN + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lineStart = 1'b0;
  logic [IW-1:0] pixIdx = '0;
  logic [DW-1:0] sampleIn = '0;
  logic [DW-1:0] pixOut;
  logic          pixValid, pixFirst, pixLast, lineErr;

  always #2 clk = ~clk;

  ccd_line_framer #(
    .DATA_W(DW), .LEAD_DUMMY(LEAD), .EFF_PIX(EFF), .TRAIL_DUMMY(TRAIL),
    .BLK_FIRST(BF), .BLK_LAST(BL)
  ) u_dut (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .pixIdx(pixIdx),
    .sampleIn(sampleIn), .pixOut(pixOut), .pixValid(pixValid),
    .pixFirst(pixFirst), .pixLast(pixLast), .lineErr(lineErr)
  );

  int    nVec = 0;
  int    nBad = 0;
  bit    done = 1'b0;
  bit    eValid = 0, eFirst = 0, eLast = 0, eErr = 0;
  int    eData = 0;
  string eTag = "R1";
  bit    mInLine = 0;
  int    mCnt = 0;

  // Sample value by kind of position; window, effective and other dummies differ (R6)
  function automatic int smp(int seed, int k);
    if (k >= BF && k <= BL)                    return (seed * 11 + k * 5) % 64;
    else if (k >= LEAD + 1 && k <= LEAD + EFF) return (seed * 23 + k * 17 + 3) % 64;
    else                                       return (seed * 3 + k * 29 + 41) % 64;
  endfunction

  // R4: floor of the window average
  function automatic int blackOf(int seed);
    int s = 0;
    for (int k = BF; k <= BL; k++) s += smp(seed, k);
    return s / NB;
  endfunction

  task automatic checkOut();
    bit bad = 0;
    nVec++;
    if (pixValid !== eValid) begin
      bad = 1;
      $display("FAIL %s valid actual=%0b expected=%0b", eTag, pixValid, eValid);
    end
    if (pixFirst !== eFirst || pixLast !== eLast) begin
      bad = 1;
      $display("FAIL R3 first/last actual=%0b%0b expected=%0b%0b",
               pixFirst, pixLast, eFirst, eLast);
    end
    if (lineErr !== eErr) begin
      bad = 1;
      $display("FAIL R7 lineErr actual=%0b expected=%0b", lineErr, eErr);
    end
    if (eValid && int'(pixOut) != eData) begin
      bad = 1;
      $display("FAIL R5 data actual=%0d expected=%0d", pixOut, eData);
    end
    if (!eValid && pixOut !== '0 && eTag == "R1") begin
      bad = 1;
      $display("FAIL R1 pixOut actual=%0d expected=0", pixOut);
    end
    if (bad) nBad++;
  endtask

  task automatic step(bit ls, int idx, int s, int blk, string tag);
    bit belongs;
    @(negedge clk);
    checkOut();
    lineStart = ls;
    pixIdx    = IW'(idx);
    sampleIn  = DW'(s);
    belongs   = ls || mInLine;
    eErr      = ls && mInLine;
    if (ls) begin
      mInLine = 1; mCnt = 1;
    end else if (mInLine) begin
      mCnt++;
      if (mCnt == LLEN) mInLine = 0;
    end
    eValid = belongs && idx >= LEAD + 1 && idx <= LEAD + EFF;
    eFirst = eValid && idx == LEAD + 1;
    eLast  = eValid && idx == LEAD + EFF;
    eData  = (s > blk) ? s - blk : 0;       // R5 clamp, black from own line (R9)
    eTag   = tag;
  endtask

  task automatic runLine(int seed, int len, string tag);
    int blk = blackOf(seed);
    for (int k = 1; k <= len; k++) step(k == 1, k, smp(seed, k), blk, tag);
  endtask

  task automatic idle(int n, int firstIdx);
    for (int i = 0; i < n; i++) step(1'b0, firstIdx + i, 63 - i, 0, "R8");
  endtask

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      checkOut();
    end
    rstN = 1'b1;
    // R8: effective-range indices before any line start
    idle(EFF, LEAD + 1);
    // R2 R3 R4 R5 R6 R9: sweep of lines with varying window and pixel data
    for (int seed = 0; seed < 64; seed++) begin
      runLine(seed, LLEN, "R2");
      idle(seed % 3, LLEN + 1);  // R8: gaps after a complete line
    end
    // R7: cut inside effective pixels, then a full line
    runLine(5, LEAD + 4, "R7");
    runLine(40, LLEN, "R7");
    // R7: cut inside the black window, then a full line
    runLine(17, BL - 1, "R7");
    runLine(58, LLEN, "R7");
    // R7: line start on the very last expected sample boundary is no error
    runLine(9, LLEN, "R2");
    runLine(33, LLEN, "R2");
    idle(4, LLEN + 1);
    @(negedge clk);
    checkOut();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule